// File: doc/BRIEF.md
# Grouped Timer Tick Generator

This block turns one peripheral clock into five single-cycle tick enables, one for each timer channel. The channels form two groups: channels 0 and 1 share one 8-bit prescaler, and channels 2 to 4 share a second. Each channel then divides its group's prescaled rate by a power of two, chosen by its own 4-bit select code. A parameter mask can mark some select codes as "use external source". A channel that holds such a code ticks once for each rising edge of its group's external clock input.

Both configuration words are static inputs, held by whatever register file sits above the block. The block keeps a copy of each field. When a field differs from its copy, the block restarts the counters that depend on that field, so the first tick after a change comes a full period later and never early. The downstream timer counters advance only in cycles where their tick is high.

Top module: `tick_gen`

## Requirements
- R1: While rst_ni is low every tick_o bit is 0. The stored fields reset to zero, so with all-zero configuration held, every channel ticks on every cycle from the first clock edge after reset release.
- R2: presc_cfg_i[7:0] is the prescaler of channels 0 and 1, and presc_cfg_i[15:8] is the prescaler of channels 2 to 4. A prescaler value p divides the clock by p+1; a value of 0 lets every cycle through.
- R3: The select code of channel c sits at mux_cfg_i[4c+3:4c]. A code n that is not marked external gives a tick period of (p+1)*2^(n+DIV_BASE) clock cycles (DIV_BASE defaults to 0).
- R4: Code n selects the external source when EXT_MASK[n] is 1 (the default marks only code 4). ext_clk_i[0] serves channels 0 and 1, and ext_clk_i[1] serves channels 2 to 4.
- R5: Each rising edge of an external input gives exactly one tick on each channel in external mode. The input is sampled at a clock edge E, and the tick is high in the cycle after edge E+2. Holding the input high gives no further ticks.
- R6: Each tick is one cycle wide. Whenever a channel's period is longer than one cycle, a tick is never followed by a tick in the next cycle.
- R7: Changing a prescaler field restarts that group's prescaler and the dividers of all its channels. The ticks of that group are then low in the following cycle, and the first tick comes one full period after the change. The other group, and a rewrite with an unchanged value, leave the phase untouched.
- R8: Changing one channel's select code restarts only that channel's divider, with the same full-period rule. The other channels keep their phase.
- R9: A channel in divider mode ignores edges on the external inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_cfg_i | input | 16 | Two prescaler fields, one per channel group |
| mux_cfg_i | input | 20 | Five 4-bit per-channel select codes |
| ext_clk_i | input | 2 | External tick sources, one per group, asynchronous |
| tick_o | output | 5 | Per-channel tick enables |

## Verification
The bench checks every cycle against a model that tracks the restart point and the period of each channel. This catches a design that starts its count with a shortened first period after a field write, or that lets a write to one group or one channel disturb the phase of another. External edges are sent while some channels are in external mode and others are not. A design that counts levels instead of edges, gets the synchronizer latency wrong, or feeds edges into divider-mode channels then shows extra, missing or displaced ticks. The period of 1 cycle and the longest periods tested catch off-by-one errors in the prescaler compare and in the power-of-two mask.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
  localparam int unsigned TG_NUM_CH    = 5;
  localparam int unsigned TG_NUM_GRP   = 2;
  localparam int unsigned TG_GRP_SPLIT = 2;
  localparam int unsigned TG_PRESC_W   = 8;
  localparam int unsigned TG_MUX_W     = 4;

  function automatic int unsigned grp_of(int unsigned ch, int unsigned split);
    return (ch < split) ? 0 : 1;
  endfunction
endpackage

// File: rtl/tg_presc.sv
module tg_presc #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] val_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tg_ext_edge.sv
module tg_ext_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic edge_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ext_i};
  end

  assign edge_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/tg_chan_div.sv
module tg_chan_div #(
  parameter int unsigned              MUX_W    = 4,
  parameter int unsigned              DIV_BASE = 0,
  parameter logic [(1<<MUX_W)-1:0]    EXT_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [MUX_W-1:0] code_i,
  input  logic             presc_tick_i,
  input  logic             ext_edge_i,
  output logic             tick_o
);
  localparam int unsigned DCW = (1 << MUX_W) - 1 + DIV_BASE;

  logic [DCW-1:0]   dcnt_q;
  logic [DCW-1:0]   mask;
  logic [MUX_W:0]   k;
  logic             is_ext;
  logic             div_hit;

  assign k       = {1'b0, code_i} + (MUX_W+1)'(DIV_BASE);
  // shift past the top leaves all ones: full-width divide
  assign mask    = ~({DCW{1'b1}} << k);
  assign is_ext  = EXT_MASK[code_i];
  assign div_hit = presc_tick_i && ((dcnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      tick_o <= 1'b0;
    end else if (restart_i) begin
      dcnt_q <= '0;
      tick_o <= 1'b0;
    end else begin
      if (presc_tick_i) dcnt_q <= dcnt_q + 1'b1;
      tick_o <= is_ext ? ext_edge_i : div_hit;
    end
  end
endmodule

// File: rtl/tick_gen.sv
module tick_gen
  import tick_gen_pkg::*;
#(
  parameter int unsigned NUM_CH    = TG_NUM_CH,
  parameter int unsigned GRP_SPLIT = TG_GRP_SPLIT,
  parameter int unsigned PRESC_W   = TG_PRESC_W,
  parameter int unsigned MUX_W     = TG_MUX_W,
  parameter int unsigned DIV_BASE  = 0,
  parameter logic [(1<<MUX_W)-1:0] EXT_MASK = 16'h0010
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [TG_NUM_GRP*PRESC_W-1:0] presc_cfg_i,
  input  logic [NUM_CH*MUX_W-1:0]       mux_cfg_i,
  input  logic [TG_NUM_GRP-1:0]         ext_clk_i,
  output logic [NUM_CH-1:0]             tick_o
);
  localparam int unsigned NUM_GRP = TG_NUM_GRP;

  logic [NUM_GRP-1:0][PRESC_W-1:0] presc_q;
  logic [NUM_CH-1:0][MUX_W-1:0]    mux_q;
  logic [NUM_GRP-1:0]              grp_chg;
  logic [NUM_GRP-1:0]              presc_tick;
  logic [NUM_GRP-1:0]              ext_edge;
  logic [NUM_CH-1:0]               mux_chg;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_chg[g] = presc_cfg_i[g*PRESC_W +: PRESC_W] != presc_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) presc_q[g] <= '0;
      else         presc_q[g] <= presc_cfg_i[g*PRESC_W +: PRESC_W];
    end

    tg_presc #(.W(PRESC_W)) u_presc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (grp_chg[g]),
      .val_i     (presc_q[g]),
      .tick_o    (presc_tick[g])
    );

    tg_ext_edge u_ext (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ext_i  (ext_clk_i[g]),
      .edge_o (ext_edge[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned G = grp_of(c, GRP_SPLIT);

    assign mux_chg[c] = mux_cfg_i[c*MUX_W +: MUX_W] != mux_q[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mux_q[c] <= '0;
      else         mux_q[c] <= mux_cfg_i[c*MUX_W +: MUX_W];
    end

    tg_chan_div #(
      .MUX_W    (MUX_W),
      .DIV_BASE (DIV_BASE),
      .EXT_MASK (EXT_MASK)
    ) u_div (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .restart_i    (mux_chg[c] | grp_chg[G]),
      .code_i       (mux_q[c]),
      .presc_tick_i (presc_tick[G]),
      .ext_edge_i   (ext_edge[G]),
      .tick_o       (tick_o[c])
    );
  end
endmodule

// File: rtl/tick_gen_checker.sv
module tick_gen_checker
  import tick_gen_pkg::*;
#(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned GRP_SPLIT = 2,
  parameter int unsigned PRESC_W   = 8,
  parameter int unsigned MUX_W     = 4,
  parameter logic [(1<<MUX_W)-1:0] EXT_MASK = '0
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [TG_NUM_GRP*PRESC_W-1:0]     presc_cfg_i,
  input logic [NUM_CH*MUX_W-1:0]           mux_cfg_i,
  input logic [TG_NUM_GRP-1:0]             ext_clk_i,
  input logic [NUM_CH-1:0]                 tick_o,
  input logic [TG_NUM_GRP-1:0][PRESC_W-1:0] presc_q,
  input logic [NUM_CH-1:0][MUX_W-1:0]      mux_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (tick_o == '0);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam int unsigned G = grp_of(c, GRP_SPLIT);

    assert_grp_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (presc_cfg_i[G*PRESC_W +: PRESC_W] != presc_q[G]) |=> !tick_o[c]);

    assert_mux_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mux_cfg_i[c*MUX_W +: MUX_W] != mux_q[c]) |=> !tick_o[c]);

    assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o[c] && (presc_q[G] != '0 || mux_q[c] != '0)) |=> !tick_o[c]);

    assert_ext_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o[c] && $past(EXT_MASK[mux_q[c]])) |-> $past(ext_clk_i[G], 3));
  end
endmodule

bind tick_gen tick_gen_checker #(
  .NUM_CH    (NUM_CH),
  .GRP_SPLIT (GRP_SPLIT),
  .PRESC_W   (PRESC_W),
  .MUX_W     (MUX_W),
  .EXT_MASK  (EXT_MASK)
) u_tick_gen_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .presc_cfg_i (presc_cfg_i),
  .mux_cfg_i   (mux_cfg_i),
  .ext_clk_i   (ext_clk_i),
  .tick_o      (tick_o),
  .presc_q     (presc_q),
  .mux_q       (mux_q)
);

// File: tb/tick_gen_bench.sv
module tick_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] presc_cfg_i = '0;
  logic [19:0] mux_cfg_i = '0;
  logic [1:0]  ext_clk_i = '0;
  logic [4:0]  tick_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // model state
  int rs [5];
  int nper [5];
  bit extm [5];
  int cur_p [2];
  int cur_m [5];
  bit hit0 [int];
  bit hit1 [int];

  logic [4:0] exp_q [$];
  string      tag_q [$];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  tick_gen u_tick_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .presc_cfg_i (presc_cfg_i),
    .mux_cfg_i   (mux_cfg_i),
    .ext_clk_i   (ext_clk_i),
    .tick_o      (tick_o)
  );

  function automatic logic [4:0] exp_vec(int cy);
    logic [4:0] v;
    for (int ch = 0; ch < 5; ch++) begin
      if (extm[ch]) v[ch] = (ch < 2) ? hit0.exists(cy) : hit1.exists(cy);
      else          v[ch] = (cy > rs[ch]) && (((cy - rs[ch]) % nper[ch]) == 0);
    end
    return v;
  endfunction

  task automatic push_window(int c, int w, string tag);
    for (int i = 1; i <= w; i++) begin
      exp_q.push_back(exp_vec(c + i));
      tag_q.push_back(tag);
    end
  endtask

  // monitor: compares mid high phase
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (tick_o !== e) begin
          n_fail++;
          $display("FAIL %s cycle %0d tick_o=%b expected=%b", t, cyc, tick_o, e);
        end
      end
    end
  end

  // driver: called at a negedge, returns at a negedge
  task automatic apply(int pa, int pb, logic [19:0] mux, int w,
                       int e0, int e1, string tag);
    int c;
    int np [2];
    c = cyc;
    np[0] = pa; np[1] = pb;
    for (int g = 0; g < 2; g++)
      if (np[g] != cur_p[g]) begin
        for (int ch = 0; ch < 5; ch++)
          if (((ch < 2) ? 0 : 1) == g) rs[ch] = c + 1;
        cur_p[g] = np[g];
      end
    for (int ch = 0; ch < 5; ch++) begin
      int code;
      code = int'(mux[ch*4 +: 4]);
      if (code != cur_m[ch]) begin
        rs[ch] = c + 1;
        cur_m[ch] = code;
      end
      extm[ch] = (code == 4);
      nper[ch] = (cur_p[(ch < 2) ? 0 : 1] + 1) << code;
    end
    if (e0 > 0) hit0[c + e0 + 3] = 1'b1;
    if (e1 > 0) hit1[c + e1 + 3] = 1'b1;
    presc_cfg_i = {pb[7:0], pa[7:0]};
    mux_cfg_i   = mux;
    push_window(c, w, tag);
    for (int i = 1; i <= w; i++) begin
      @(negedge clk_i);
      if (i == e0)     ext_clk_i[0] = 1'b1;
      if (i == e0 + 6) ext_clk_i[0] = 1'b0;
      if (i == e1)     ext_clk_i[1] = 1'b1;
      if (i == e1 + 6) ext_clk_i[1] = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (tick_o !== 5'b0) begin
      n_fail++;
      $display("FAIL R1 reset tick_o=%b expected=%b", tick_o, 5'b0);
    end
    for (int ch = 0; ch < 5; ch++) begin
      rs[ch] = cyc; nper[ch] = 1; extm[ch] = 0; cur_m[ch] = 0;
    end
    cur_p[0] = 0; cur_p[1] = 0;
    rst_ni = 1'b1;
    push_window(cyc, 8, "R1");
    repeat (8) @(negedge clk_i);
    // R2 group A prescaled by 3, group B untouched
    apply(2, 0, 20'h00000, 24, -1, -1, "R2 R7");
    // R3 per-channel codes, R8 untouched channels keep phase
    apply(2, 0, 20'h31200, 48, -1, -1, "R3 R8");
    // R7 group B prescaler change
    apply(2, 4, 20'h31200, 90, -1, -1, "R7");
    // R4 R5 external mode on ch0 and ch2, R9 ch1 ignores edge
    apply(2, 4, 20'h31424, 40, 5, 12, "R4 R5 R9");
    // R5 second edge on group B only
    apply(2, 4, 20'h31424, 30, -1, 4, "R5");
    // R6 period 2 and 1, R9 divider channels ignore ext1 edge
    apply(0, 4, 20'h31401, 24, 3, 6, "R6 R9");
    // R7 R8 rewrite with unchanged values keeps phase
    apply(0, 4, 20'h31401, 30, -1, -1, "R7 R8 unchanged");
    // R3 longer code on group B, prescaler 0
    apply(0, 0, 20'h52401, 70, -1, -1, "R3");
    @(negedge clk_i);
    @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule